// File: doc/BRIEF.md
# Paired-Channel Edge-Placed PWM Generator

This block produces one pulse-width-modulated output from a pair of timer channels. A free-running up counter sweeps from a programmable start value to a programmable limit and then wraps. Each channel compares its own value against the counter. The even channel's match moves the output to its active level. The odd channel's match moves it back to the idle level. The start of each period also returns it to idle. Both edges can therefore be placed anywhere in the period, and the pulse width is set by the gap between the two compare values.

The generator works only when the mode inputs select paired operation. Any other mode combination leaves the output low and disabled, and no flags are raised. Each channel keeps a sticky match flag. Software clears a flag with a one-cycle clear strobe. When the channel's interrupt enable is set, the flag also drives an interrupt request. All outputs are registered, so every effect appears one clock after the counter value that causes it.

Top module: `cmb_pwm_pair`

## Requirements
- R1: Paired operation is active only when `cfg_join`=1 and `cfg_multi`, `cfg_cap_dual` and `cfg_centre` are all 0. Otherwise `pwm_out` and `pwm_oe` are 0 and no flag is set.
- R2: The counter starts at `cnt_start` and steps up by one per clock. On the clock after it reaches or passes `cnt_limit`, it reloads `cnt_start`. Consecutive rising edges of `pwm_out` are therefore `cnt_limit`−`cnt_start`+1 clocks apart.
- R3: When `cmp_even` < `cmp_odd` (both within the count range), the output holds its active level for exactly `cmp_odd`−`cmp_even` clocks per period.
- R4: `flag_even` rises on the clock after the counter equals `cmp_even`. `irq_even` equals `flag_even` AND `irq_en_even`.
- R5: `flag_odd` rises on the clock after the counter equals `cmp_odd`. `irq_odd` equals `flag_odd` AND `irq_en_odd`.
- R6: With `lvl_even`=2'b10 (bit 1 = high-true select, bit 0 = low-true select), the output goes low after the counter equals `cnt_start`, high after the even match, and low after the odd match. Each change appears one clock after the counter value that causes it.
- R7: With `lvl_even` bit 0 = 1 (bit 1 don't care), the output goes high after the start value, low after the even match, and high after the odd match.
- R8: `lvl_odd` has no effect on `pwm_out` or `pwm_oe`.
- R9: With `lvl_even`=2'b00, `pwm_oe` and `pwm_out` are 0.
- R10: A flag stays set until its clear strobe is seen. A clear on the same clock as a new match leaves the flag set.
- R11: When several events hit on the same count, the later one in the order start, even match, odd match decides the output.
- R12: During reset the counter loads `cnt_start`, and `pwm_out`, `pwm_oe` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_join | input | 1 | Pair-join mode select |
| cfg_multi | input | 1 | Alternate multi-join mode (blocks paired output) |
| cfg_cap_dual | input | 1 | Dual-capture mode (blocks paired output) |
| cfg_centre | input | 1 | Centre-aligned counting (blocks paired output) |
| cnt_start | input | CNT_W | Counter start value |
| cnt_limit | input | CNT_W | Counter limit value |
| cmp_even | input | CNT_W | Even channel compare value |
| cmp_odd | input | CNT_W | Odd channel compare value |
| lvl_even | input | 2 | Even channel level select {high-true, low-true} |
| lvl_odd | input | 2 | Odd channel level select (unused by the waveform) |
| irq_en_even | input | 1 | Even channel interrupt enable |
| irq_en_odd | input | 1 | Odd channel interrupt enable |
| clr_even | input | 1 | Even flag clear strobe |
| clr_odd | input | 1 | Odd flag clear strobe |
| pwm_out | output | 1 | Paired PWM output |
| pwm_oe | output | 1 | Output enable of the paired output |
| flag_even | output | 1 | Even channel match flag |
| flag_odd | output | 1 | Odd channel match flag |
| irq_even | output | 1 | Even channel interrupt request |
| irq_odd | output | 1 | Odd channel interrupt request |

## Verification
On every clock, the assertions check the one-clock edge response to each match in both polarities, that the odd match wins over a coincident even match, that the output stays quiet outside paired mode, that flags stay sticky and that a set beats a clear, and that the counter keeps stepping below the limit. Only the bench scenarios can show the whole-period properties: the spacing between rising edges, the pulse width taken from the compare gap, the first edge position after reset, and the fact that changing the odd level bits leaves the waveform unchanged. The bench also runs randomized configurations against a cycle model to cover mode mixes and start/limit pairs.

// File: rtl/cmb_pwm_pkg.sv
// Shared types and helpers for the paired-channel PWM generator.
// Assumes level-select encoding {high-true, low-true}.
package cmb_pwm_pkg;

    // Events decoded from the counter on one clock.
    typedef struct packed {
        logic at_start;
        logic hit_even;
        logic hit_odd;
    } pair_evt_t;

    // True when the level-select field drives the output.
    function automatic logic lvl_drives(input logic [1:0] lvl);
        return lvl != 2'b00;
    endfunction

    // Idle level taken at period start: high for low-true select.
    function automatic logic lvl_idle(input logic [1:0] lvl);
        return lvl[0];
    endfunction

endpackage

// File: rtl/cmb_pwm_counter.sv
// Free-running up counter for the paired PWM.
// Counts from start to limit, then reloads start. A limit below the
// current value reloads on the next clock. Reset loads start.
module cmb_pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] limit_val,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    // Decide whether this clock ends the period.
    always_comb begin
        wrap = (cnt_q >= limit_val);
    end

    // Advance or reload the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= start_val;
        else if (wrap) cnt_q <= start_val;
        else           cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    // Below the limit the counter must keep moving.
    p_cnt_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < limit_val) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/cmb_pwm_flag.sv
// Sticky match flag with a clear strobe and a gated interrupt request.
// Assumes a set on the same clock as a clear wins.
module cmb_pwm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic flag_q;

    // Hold the flag until a clear that has no new match beside it.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= set_i | (flag_q & ~clr_i);
    end

    assign flag = flag_q;
    assign irq  = flag_q & irq_en;

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
    p_set_beats_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);

endmodule

// File: rtl/cmb_pwm_edge.sv
// Output shaper: turns the decoded events into the paired waveform.
// Priority among events on one count is odd match, then even match,
// then period start. Outside paired mode the output is held low.
module cmb_pwm_edge
    import cmb_pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active,
    input  logic [1:0] lvl,
    input  pair_evt_t evt,
    output logic      pwm,
    output logic      oe
);
    logic pwm_q, pwm_d, oe_q;
    logic idle;

    // Compute the next output level from the events.
    always_comb begin
        idle  = lvl_idle(lvl);
        pwm_d = pwm_q;
        if (!active || !lvl_drives(lvl)) begin
            pwm_d = 1'b0;
        end else begin
            if (evt.at_start) pwm_d = idle;
            if (evt.hit_even) pwm_d = ~idle;
            if (evt.hit_odd)  pwm_d = idle;
        end
    end

    // Register the output and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            pwm_q <= pwm_d;
            oe_q  <= active && lvl_drives(lvl);
        end
    end

    assign pwm = pwm_q;
    assign oe  = oe_q;

    p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!pwm_q && !oe_q));
    p_rise_on_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && lvl == 2'b10 && evt.hit_even && !evt.hit_odd) |=> pwm_q);
    p_fall_on_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && lvl[0] && evt.hit_even && !evt.hit_odd) |=> !pwm_q);
    p_odd_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && lvl == 2'b10 && evt.hit_odd) |=> !pwm_q);
    p_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == 2'b00) |=> (!oe_q && !pwm_q));

endmodule

// File: rtl/cmb_pwm_pair.sv
// Top of the paired-channel PWM generator. Decodes the mode, compares
// the counter with both channel values, and drives the shaper and the
// two match flags. Assumes all inputs are synchronous to clk.
module cmb_pwm_pair
    import cmb_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_join,
    input  logic             cfg_multi,
    input  logic             cfg_cap_dual,
    input  logic             cfg_centre,
    input  logic [CNT_W-1:0] cnt_start,
    input  logic [CNT_W-1:0] cnt_limit,
    input  logic [CNT_W-1:0] cmp_even,
    input  logic [CNT_W-1:0] cmp_odd,
    input  logic [1:0]       lvl_even,
    input  logic [1:0]       lvl_odd,
    input  logic             irq_en_even,
    input  logic             irq_en_odd,
    input  logic             clr_even,
    input  logic             clr_odd,
    output logic             pwm_out,
    output logic             pwm_oe,
    output logic             flag_even,
    output logic             flag_odd,
    output logic             irq_even,
    output logic             irq_odd
);
    localparam int NCH = 2;

    logic [CNT_W-1:0] cnt;
    logic             active;
    pair_evt_t        evt;
    logic [NCH-1:0]   f_set, f_clr, f_ie, f_q, f_irq;
    logic [1:0]       lvl_unused;

    // Paired mode only with the join bit and no competing mode.
    always_comb begin
        active = cfg_join & ~cfg_multi & ~cfg_cap_dual & ~cfg_centre;
    end

    // Decode the counter events for this clock.
    always_comb begin
        evt.at_start = (cnt == cnt_start);
        evt.hit_even = (cnt == cmp_even);
        evt.hit_odd  = (cnt == cmp_odd);
    end

    // The odd level select plays no part in the paired waveform.
    assign lvl_unused = lvl_odd;

    cmb_pwm_counter #(.CNT_W(CNT_W)) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_val (cnt_start),
        .limit_val (cnt_limit),
        .cnt       (cnt)
    );

    cmb_pwm_edge i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .lvl    (lvl_even),
        .evt    (evt),
        .pwm    (pwm_out),
        .oe     (pwm_oe)
    );

    // Route the per-channel flag controls into arrays.
    always_comb begin
        f_set = {active & evt.hit_odd, active & evt.hit_even};
        f_clr = {clr_odd, clr_even};
        f_ie  = {irq_en_odd, irq_en_even};
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_flag
        cmb_pwm_flag i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (f_set[ch]),
            .clr_i  (f_clr[ch]),
            .irq_en (f_ie[ch]),
            .flag   (f_q[ch]),
            .irq    (f_irq[ch])
        );
    end

    assign flag_even = f_q[0];
    assign flag_odd  = f_q[1];
    assign irq_even  = f_irq[0];
    assign irq_odd   = f_irq[1];

    p_even_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt == cmp_even) |=> flag_even);
    p_odd_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt == cmp_odd) |=> flag_odd);

endmodule

// File: tb/test_cmb_pwm_pair.sv
module test_cmb_pwm_pair;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_join = 1'b1, cfg_multi = 1'b0, cfg_cap_dual = 1'b0, cfg_centre = 1'b0;
    logic [W-1:0] cnt_start = '0, cnt_limit = 16'd9, cmp_even = 16'd2, cmp_odd = 16'd5;
    logic [1:0] lvl_even = 2'b10, lvl_odd = 2'b00;
    logic irq_en_even = 1'b0, irq_en_odd = 1'b0, clr_even = 1'b0, clr_odd = 1'b0;
    logic pwm_out, pwm_oe, flag_even, flag_odd, irq_even, irq_odd;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cmb_pwm_pair #(.CNT_W(W)) i_cmb_pwm_pair (
        .clk(clk), .rst_n(rst_n),
        .cfg_join(cfg_join), .cfg_multi(cfg_multi),
        .cfg_cap_dual(cfg_cap_dual), .cfg_centre(cfg_centre),
        .cnt_start(cnt_start), .cnt_limit(cnt_limit),
        .cmp_even(cmp_even), .cmp_odd(cmp_odd),
        .lvl_even(lvl_even), .lvl_odd(lvl_odd),
        .irq_en_even(irq_en_even), .irq_en_odd(irq_en_odd),
        .clr_even(clr_even), .clr_odd(clr_odd),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe),
        .flag_even(flag_even), .flag_odd(flag_odd),
        .irq_even(irq_even), .irq_odd(irq_odd)
    );

    // Reference model built from the requirements.
    logic [W-1:0] m_cnt;
    logic m_pwm, m_oe, m_fe, m_fo;

    function automatic logic mdl_active();
        return cfg_join && !cfg_multi && !cfg_cap_dual && !cfg_centre;
    endfunction

    function automatic logic mdl_next_pwm(input logic cur);
        logic n;
        n = cur;
        if (!mdl_active() || lvl_even == 2'b00) return 1'b0;
        if (m_cnt == cnt_start) n = lvl_even[0];
        if (m_cnt == cmp_even)  n = ~lvl_even[0];
        if (m_cnt == cmp_odd)   n = lvl_even[0];
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= cnt_start; m_pwm <= 1'b0; m_oe <= 1'b0; m_fe <= 1'b0; m_fo <= 1'b0;
        end else begin
            m_cnt <= (m_cnt >= cnt_limit) ? cnt_start : m_cnt + 1'b1;
            m_pwm <= mdl_next_pwm(m_pwm);
            m_oe  <= mdl_active() && lvl_even != 2'b00;
            m_fe  <= (mdl_active() && m_cnt == cmp_even) | (m_fe & ~clr_even);
            m_fo  <= (mdl_active() && m_cnt == cmp_odd)  | (m_fo & ~clr_odd);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock, then compare every output with the model at the falling edge.
    task automatic tick(input string tag);
        string mt;
        @(posedge clk);
        @(negedge clk);
        mt = !mdl_active() ? "R1" : (lvl_even == 2'b00 ? "R9" : tag);
        chk(mt, "pwm_out", pwm_out, m_pwm);
        chk(mt, "pwm_oe", pwm_oe, m_oe);
        chk(mdl_active() ? "R4" : "R1", "flag_even", flag_even, m_fe);
        chk(mdl_active() ? "R5" : "R1", "flag_odd", flag_odd, m_fo);
        chk("R4", "irq_even", irq_even, m_fe & irq_en_even);
        chk("R5", "irq_odd", irq_odd, m_fo & irq_en_odd);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clr_even = 1'b0; clr_odd = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12", "reset pwm_out", pwm_out, 0);
        chk("R12", "reset pwm_oe", pwm_oe, 0);
        chk("R12", "reset flags", {flag_even, flag_odd}, 0);
        rst_n = 1'b1;
    endtask

    // Measure complete high and low runs of the output.
    task automatic measure(input int ncyc, output int hi_w, output int lo_w);
        logic prev;
        int run;
        bit started;
        hi_w = -1; lo_w = -1; run = 0; started = 0;
        prev = pwm_out;
        for (int i = 0; i < ncyc; i++) begin
            tick("R6");
            run++;
            if (pwm_out != prev) begin
                if (started) begin
                    if (prev) hi_w = run - 1; else lo_w = run - 1;
                end
                started = 1;
                run = 1;
                prev = pwm_out;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int hi, lo, k;
        void'($urandom(32'd1234));

        // R12: first edge after reset lands at the even match.
        cnt_start = 16'd4; cnt_limit = 16'd23; cmp_even = 16'd8; cmp_odd = 16'd14;
        lvl_even = 2'b10;
        do_reset();
        k = 0;
        for (int i = 0; i < 30 && k == 0; i++) begin
            tick("R12");
            if (pwm_out) k = i + 1;
        end
        chk("R12", "first rise clocks after release", k, 8 - 4 + 1);

        // R2, R3, R6: period and width, high-true.
        measure(80, hi, lo);
        chk("R3", "high width", hi, 6);
        chk("R2", "period", hi + lo, 20);

        // R7: low-true, both encodings of bit 1.
        for (int v = 0; v < 2; v++) begin
            lvl_even = v ? 2'b11 : 2'b01;
            do_reset();
            measure(80, hi, lo);
            chk("R7", "low width", lo, 6);
            chk("R2", "period", hi + lo, 20);
        end

        // R3: a different gap at a different period.
        cnt_start = 16'd0; cnt_limit = 16'd31; cmp_even = 16'd3; cmp_odd = 16'd28; lvl_even = 2'b10;
        do_reset();
        measure(120, hi, lo);
        chk("R3", "high width", hi, 25);
        chk("R2", "period", hi + lo, 32);

        // R8: churn the odd level select; waveform must match the model.
        for (int i = 0; i < 64; i++) begin
            lvl_odd = 2'($urandom);
            tick("R8");
        end

        // R11: equal compare values; odd wins, output never rises.
        cmp_even = 16'd10; cmp_odd = 16'd10;
        do_reset();
        k = 0;
        for (int i = 0; i < 64; i++) begin
            tick("R11");
            if (pwm_out) k++;
        end
        chk("R11", "high clocks with equal compares", k, 0);

        // R11: even match on the start value wins over start.
        cmp_even = 16'd0; cmp_odd = 16'd5;
        do_reset();
        measure(96, hi, lo);
        chk("R11", "high width with even at start", hi, 5);

        // R10: clear coincident with a match keeps the flag; a lone clear clears.
        cmp_even = 16'd6; cmp_odd = 16'd20; irq_en_even = 1'b1;
        do_reset();
        for (int i = 0; i < 40; i++) begin
            clr_even = (m_cnt == cmp_even);
            tick("R10");
            if (clr_even) chk("R10", "flag after clear at match", flag_even, 1);
        end
        clr_even = 1'b0;
        while (m_cnt == cmp_even) tick("R10");
        clr_even = 1'b1;
        tick("R10");
        clr_even = 1'b0;
        chk("R10", "flag after lone clear", flag_even, 0);
        chk("R4", "irq after clear", irq_even, 0);

        // R1: each blocking mode bit, and join off.
        for (int mbit = 0; mbit < 4; mbit++) begin
            cfg_join = (mbit != 0); cfg_multi = (mbit == 1);
            cfg_cap_dual = (mbit == 2); cfg_centre = (mbit == 3);
            do_reset();
            for (int i = 0; i < 40; i++) tick("R1");
            chk("R1", "pwm_oe off-mode", pwm_oe, 0);
            chk("R1", "flag_even off-mode", flag_even, 0);
        end
        cfg_join = 1'b1; cfg_multi = 1'b0; cfg_cap_dual = 1'b0; cfg_centre = 1'b0;

        // R9: no drive with level select 00.
        lvl_even = 2'b00;
        do_reset();
        for (int i = 0; i < 40; i++) tick("R9");
        chk("R9", "pwm_oe undriven", pwm_oe, 0);

        // Random configurations against the model.
        for (int c = 0; c < 40; c++) begin
            cnt_start = 16'($urandom_range(0, 20));
            cnt_limit = cnt_start + 16'($urandom_range(2, 30));
            cmp_even = cnt_start + 16'($urandom_range(0, cnt_limit - cnt_start));
            cmp_odd  = cnt_start + 16'($urandom_range(0, cnt_limit - cnt_start));
            lvl_even = 2'($urandom);
            k = $urandom_range(0, 7);
            cfg_join = (k != 1); cfg_multi = (k == 2); cfg_cap_dual = (k == 3); cfg_centre = 1'b0;
            do_reset();
            for (int i = 0; i < 100; i++) begin
                irq_en_even = 1'($urandom); irq_en_odd = 1'($urandom);
                clr_even = ($urandom_range(0, 7) == 0); clr_odd = ($urandom_range(0, 7) == 0);
                lvl_odd = 2'($urandom);
                tick(lvl_even[0] ? "R7" : "R6");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule